// File: doc/BRIEF.md
# Condition Field Mask-Mode Logic Unit

This unit executes a family of operations that combine a 4-bit condition field with 64-bit integer data. Each operation is steered by a 4-bit mask and a 4-bit mode. For every field position k, a test bit is formed: it is 1 when mask bit k is set and mode bit k equals the probed input bit k. Depending on the operation, the four test bits are reduced to one bit, packed into an integer, written back as a whole condition field, or written into a single addressed condition bit. One variant is a masked field move that XORs the mode onto the result.

The unit accepts one operation per clock. Results appear one clock later with an output valid strobe. The destination's old field value comes in as an operand, so the surrounding pipeline can perform a read-modify-write that keeps the masked-out bits. The surrounding pipeline owns register-file storage and decode.

Top module: `cfm_unit`

## Requirements
- R1: For k in 0..3, the test bit is t[k] = mask[k] & (mode[k] == p[k]), where p is the probed input of the selected operation and index k is the vector bit position.
- R2: Op code 0 (field to integer bit) probes the source field. It sets out_int[0] to the OR of t when merge=1 and to the AND of t when merge=0. All other out_int bits are 0 and out_int_we=1.
- R3: Op code 1 (field to integer nibble) probes the source field and gives out_int = t in bits 3:0 with zeros above, out_int_we=1.
- R4: Op code 2 (integer nibble to field) probes in_int[3:0], bit k against in_int[k], and writes out_fld with out_fld_we=1.
- R5: Op code 3 (integer bit to field) probes in_int[0] in all four positions. When in_int_is_r0=1, zero is probed instead of in_int[0].
- R6: Op codes 2, 3 and 4 write a whole field. Op 4 probes the source field. Where mask is 0, out_fld keeps in_dst_old when merge=1 and is 0 when merge=0.
- R7: Op code 5 (masked move) gives out_fld = ((mask & src) | (merge ? old & ~mask : 0)) ^ mode, with out_fld_we=1.
- R8: Op code 6 probes the source field and reduces t as in R2. It writes only that one bit: out_bit_we=1, out_bit_fld=in_bit_tgt[4:2], out_bit_idx=in_bit_tgt[1:0] and out_bit_val equal to the reduction.
- R9: When in_record=1 on op 0 or 1, out_sum_we=1 and out_sum = {0, eq, gt, lt}, where bit 0 is lt, bit 1 is gt and bit 2 is eq of the signed 64-bit result against zero.
- R10: Outputs register one clock after in_valid=1, with out_valid=1. At most one of out_int_we, out_fld_we and out_bit_we is set. Outputs an op does not use are 0. Op code 7 writes nothing. Without in_valid, out_valid and all write enables are 0.
- R11: With op 3 and in_int_is_r0=1, three settings act as immediates. Mask 1111, merge=0 and mode=~v loads v. Merge=1 with mode 0000 sets the masked bits. Merge=1 with mode 1111 clears the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code 0..7 |
| in_mask | input | 4 | Bit mask |
| in_mode | input | 4 | Compare/invert mode |
| in_merge | input | 1 | OR-reduce / keep masked-out bits |
| in_record | input | 1 | Request summary field |
| in_src_fld | input | 4 | Source condition field |
| in_dst_old | input | 4 | Old value of destination field |
| in_int | input | 64 | Integer operand |
| in_int_is_r0 | input | 1 | Integer operand is register zero |
| in_bit_tgt | input | 5 | Single-bit target: field[4:2], bit[1:0] |
| out_valid | output | 1 | Result valid |
| out_int | output | 64 | Integer result |
| out_int_we | output | 1 | Integer result write |
| out_fld | output | 4 | New destination field |
| out_fld_we | output | 1 | Field write |
| out_bit_we | output | 1 | Single-bit write |
| out_bit_fld | output | 3 | Field index of bit write |
| out_bit_idx | output | 2 | Bit index of bit write |
| out_bit_val | output | 1 | Bit value |
| out_sum_we | output | 1 | Summary field write |
| out_sum | output | 4 | Summary field {0,eq,gt,lt} |

## Verification
The integer result and the summary field are produced in the same cycle when record is set on op 0 or 1. The bench sets record at random on those ops and checks in the same sample that the integer value and its lt/gt/eq summary agree. The merge of old destination bits and the mode XOR of the masked move also land in one result. Random old values, masks and modes with merge on and off check that the kept bits and the inverted bits both match a bench model.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int FLD_W  = 4;
  localparam int NUM_FLD = 8;
  localparam int FIDX_W = $clog2(NUM_FLD);
  localparam int BIDX_W = $clog2(FLD_W);
  localparam int TGT_W  = FIDX_W + BIDX_W;

  typedef enum logic [2:0] {
    OP_FLD2BIT = 3'd0,
    OP_FLD2INT = 3'd1,
    OP_INT4FLD = 3'd2,
    OP_INT1FLD = 3'd3,
    OP_FLD2FLD = 3'd4,
    OP_FLDMOVE = 3'd5,
    OP_FLD2CRB = 3'd6,
    OP_NONE    = 3'd7
  } cfm_op_e;
endpackage

// File: rtl/cfm_rst_sync.sv
module cfm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/cfm_test_bits.sv
module cfm_test_bits #(
  parameter int W = cfm_pkg::FLD_W
) (
  input  logic [W-1:0] mask,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] probe,
  output logic [W-1:0] tbits,
  output logic         any_hit,
  output logic         all_hit
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign tbits[k] = mask[k] & ~(mode[k] ^ probe[k]);
  end

  assign any_hit = |tbits;
  assign all_hit = &tbits;
endmodule

// File: rtl/cfm_field_merge.sv
module cfm_field_merge #(
  parameter int W = cfm_pkg::FLD_W
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] old,
  input  logic [W-1:0] mode,
  input  logic         keep_old,
  input  logic         invert,
  output logic [W-1:0] result
);
  logic [W-1:0] kept;
  logic [W-1:0] flip;

  assign kept   = keep_old ? (old & ~mask) : '0;
  assign flip   = invert ? mode : '0;
  assign result = (base | kept) ^ flip;
endmodule

// File: rtl/cfm_summary.sv
module cfm_summary #(
  parameter int INT_W = 64,
  parameter int W     = cfm_pkg::FLD_W
) (
  input  logic [INT_W-1:0] value,
  output logic [W-1:0]     sum
);
  logic is_neg, is_zero;

  assign is_neg  = value[INT_W-1];
  assign is_zero = (value == '0);

  always_comb begin
    sum    = '0;
    sum[0] = is_neg;
    sum[1] = ~is_neg & ~is_zero;
    sum[2] = is_zero;
  end
endmodule

// File: rtl/cfm_unit.sv
module cfm_unit #(
  parameter int INT_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [2:0]                   in_op,
  input  logic [cfm_pkg::FLD_W-1:0]    in_mask,
  input  logic [cfm_pkg::FLD_W-1:0]    in_mode,
  input  logic                         in_merge,
  input  logic                         in_record,
  input  logic [cfm_pkg::FLD_W-1:0]    in_src_fld,
  input  logic [cfm_pkg::FLD_W-1:0]    in_dst_old,
  input  logic [INT_W-1:0]             in_int,
  input  logic                         in_int_is_r0,
  input  logic [cfm_pkg::TGT_W-1:0]    in_bit_tgt,
  output logic                         out_valid,
  output logic [INT_W-1:0]             out_int,
  output logic                         out_int_we,
  output logic [cfm_pkg::FLD_W-1:0]    out_fld,
  output logic                         out_fld_we,
  output logic                         out_bit_we,
  output logic [cfm_pkg::FIDX_W-1:0]   out_bit_fld,
  output logic [cfm_pkg::BIDX_W-1:0]   out_bit_idx,
  output logic                         out_bit_val,
  output logic                         out_sum_we,
  output logic [cfm_pkg::FLD_W-1:0]    out_sum
);
  import cfm_pkg::*;

  cfm_op_e op;
  assign op = cfm_op_e'(in_op);

  logic rst_n_s;
  cfm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  // Probe selection and field-base selection.
  logic [FLD_W-1:0] probe, tbits, fld_base, fld_res;
  logic             any_hit, all_hit, reduced, invert;
  logic             int_lsb;

  assign int_lsb = in_int_is_r0 ? 1'b0 : in_int[0];

  always_comb begin
    probe = in_src_fld;
    unique case (op)
      OP_INT4FLD: probe = in_int[FLD_W-1:0];
      OP_INT1FLD: probe = {FLD_W{int_lsb}};
      default:    probe = in_src_fld;
    endcase
  end

  cfm_test_bits #(.W(FLD_W)) u_test (
    .mask(in_mask), .mode(in_mode), .probe(probe),
    .tbits(tbits), .any_hit(any_hit), .all_hit(all_hit)
  );

  assign reduced  = in_merge ? any_hit : all_hit;
  assign invert   = (op == OP_FLDMOVE);
  assign fld_base = invert ? (in_mask & in_src_fld) : tbits;

  cfm_field_merge #(.W(FLD_W)) u_merge (
    .base(fld_base), .mask(in_mask), .old(in_dst_old), .mode(in_mode),
    .keep_old(in_merge), .invert(invert), .result(fld_res)
  );

  // Next-state decode.
  logic             int_we_d, fld_we_d, bit_we_d, sum_we_d;
  logic [INT_W-1:0] int_d;
  logic [FLD_W-1:0] fld_d, sum_d;
  logic [FIDX_W-1:0] bfld_d;
  logic [BIDX_W-1:0] bidx_d;
  logic             bval_d;

  always_comb begin
    int_we_d = 1'b0;
    fld_we_d = 1'b0;
    bit_we_d = 1'b0;
    int_d    = '0;
    fld_d    = '0;
    bfld_d   = '0;
    bidx_d   = '0;
    bval_d   = 1'b0;
    unique case (op)
      OP_FLD2BIT: begin
        int_we_d = 1'b1;
        int_d[0] = reduced;
      end
      OP_FLD2INT: begin
        int_we_d         = 1'b1;
        int_d[FLD_W-1:0] = tbits;
      end
      OP_INT4FLD, OP_INT1FLD, OP_FLD2FLD, OP_FLDMOVE: begin
        fld_we_d = 1'b1;
        fld_d    = fld_res;
      end
      OP_FLD2CRB: begin
        bit_we_d = 1'b1;
        bfld_d   = in_bit_tgt[TGT_W-1:BIDX_W];
        bidx_d   = in_bit_tgt[BIDX_W-1:0];
        bval_d   = reduced;
      end
      default: ;
    endcase
  end

  cfm_summary #(.INT_W(INT_W), .W(FLD_W)) u_sum (.value(int_d), .sum(sum_d));
  assign sum_we_d = in_record & int_we_d;

  // Register stage.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_valid   <= 1'b0;
      out_int_we  <= 1'b0;
      out_fld_we  <= 1'b0;
      out_bit_we  <= 1'b0;
      out_sum_we  <= 1'b0;
      out_int     <= '0;
      out_fld     <= '0;
      out_bit_fld <= '0;
      out_bit_idx <= '0;
      out_bit_val <= 1'b0;
      out_sum     <= '0;
    end else begin
      out_valid  <= in_valid;
      out_int_we <= in_valid & int_we_d;
      out_fld_we <= in_valid & fld_we_d;
      out_bit_we <= in_valid & bit_we_d;
      out_sum_we <= in_valid & sum_we_d;
      if (in_valid) begin
        out_int     <= int_d;
        out_fld     <= fld_d;
        out_bit_fld <= bfld_d;
        out_bit_idx <= bidx_d;
        out_bit_val <= bval_d;
        out_sum     <= sum_we_d ? sum_d : '0;
      end
    end
  end
endmodule

// File: rtl/cfm_unit_chk.sv
module cfm_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  in_op,
  input logic [3:0]  in_mask,
  input logic [3:0]  in_dst_old,
  input logic        in_merge,
  input logic        out_valid,
  input logic [63:0] out_int,
  input logic        out_int_we,
  input logic [3:0]  out_fld,
  input logic        out_fld_we,
  input logic        out_bit_we,
  input logic        out_sum_we,
  input logic [3:0]  out_sum
);
  logic whole_fld;
  assign whole_fld = in_valid && (in_op == 3'd2 || in_op == 3'd3 || in_op == 3'd4);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_int_we && !out_fld_we && !out_bit_we));

  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_int_we, out_fld_we, out_bit_we}));

  assert_int_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_int_we |-> (out_int[63:4] == '0));

  assert_keep_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (whole_fld && in_merge) |=>
      (out_fld_we && ((out_fld & ~$past(in_mask)) == ($past(in_dst_old) & ~$past(in_mask)))));

  assert_zero_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (whole_fld && !in_merge) |=> (out_fld_we && ((out_fld & ~$past(in_mask)) == 4'b0)));

  assert_summary_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_sum_we |-> (out_int_we && !out_sum[3] && ($countones(out_sum[2:0]) == 1)));
endmodule

bind cfm_unit cfm_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_op(in_op),
  .in_mask(in_mask), .in_dst_old(in_dst_old), .in_merge(in_merge),
  .out_valid(out_valid), .out_int(out_int), .out_int_we(out_int_we),
  .out_fld(out_fld), .out_fld_we(out_fld_we), .out_bit_we(out_bit_we),
  .out_sum_we(out_sum_we), .out_sum(out_sum)
);

// File: tb/cfm_unit_test.sv
module cfm_unit_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_merge, in_record, in_int_is_r0;
  logic [2:0]  in_op;
  logic [3:0]  in_mask, in_mode, in_src_fld, in_dst_old;
  logic [63:0] in_int;
  logic [4:0]  in_bit_tgt;
  logic        out_valid, out_int_we, out_fld_we, out_bit_we, out_bit_val, out_sum_we;
  logic [63:0] out_int;
  logic [3:0]  out_fld, out_sum;
  logic [2:0]  out_bit_fld;
  logic [1:0]  out_bit_idx;

  cfm_unit uut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] tb_tests(input logic [3:0] m, input logic [3:0] md, input logic [3:0] p);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = m[k] && (md[k] == p[k]);
    return r;
  endfunction

  // Expected outputs packed: {int_we, int, fld_we, fld, bit_we, bfld, bidx, bval, sum_we, sum}
  task automatic apply(input logic [2:0] op, input logic [3:0] m, input logic [3:0] md,
                       input logic mg, input logic rc, input logic [3:0] src,
                       input logic [3:0] old, input logic [63:0] iv, input logic r0,
                       input logic [4:0] tgt, input string req);
    logic [3:0] t, p, e_fld, e_sum;
    logic [63:0] e_int;
    logic e_iwe, e_fwe, e_bwe, e_swe, e_bval, red;
    logic [2:0] e_bf;
    logic [1:0] e_bi;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_mask = m; in_mode = md; in_merge = mg;
    in_record = rc; in_src_fld = src; in_dst_old = old; in_int = iv;
    in_int_is_r0 = r0; in_bit_tgt = tgt;
    p = src;
    if (op == 3'd2) p = iv[3:0];
    if (op == 3'd3) p = (r0 ? 4'b0000 : {4{iv[0]}});
    t = tb_tests(m, md, p);
    red = mg ? (t != 0) : (t == 4'hf);
    e_int = 0; e_fld = 0; e_sum = 0; e_bf = 0; e_bi = 0; e_bval = 0;
    e_iwe = 0; e_fwe = 0; e_bwe = 0; e_swe = 0;
    case (op)
      3'd0: begin e_iwe = 1; e_int = {63'd0, red}; end
      3'd1: begin e_iwe = 1; e_int = {60'd0, t}; end
      3'd2, 3'd3, 3'd4: begin e_fwe = 1; e_fld = t | (mg ? (old & ~m) : 4'b0); end
      3'd5: begin e_fwe = 1; e_fld = ((m & src) | (mg ? (old & ~m) : 4'b0)) ^ md; end
      3'd6: begin e_bwe = 1; e_bf = tgt[4:2]; e_bi = tgt[1:0]; e_bval = red; end
      default: ;
    endcase
    if (e_iwe && rc) begin
      e_swe = 1;
      e_sum[0] = ($signed(e_int) < 0);
      e_sum[1] = ($signed(e_int) > 0);
      e_sum[2] = (e_int == 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, {req, " R10 valid"}, 80'(out_valid), 80'(1));
    chk({out_int_we, out_int} == {e_iwe, e_int}, {req, " int"},
        80'({out_int_we, out_int}), 80'({e_iwe, e_int}));
    chk({out_fld_we, out_fld} == {e_fwe, e_fld}, {req, " fld"},
        80'({out_fld_we, out_fld}), 80'({e_fwe, e_fld}));
    chk({out_bit_we, out_bit_fld, out_bit_idx, out_bit_val} == {e_bwe, e_bf, e_bi, e_bval},
        {req, " bit"}, 80'({out_bit_we, out_bit_fld, out_bit_idx, out_bit_val}),
        80'({e_bwe, e_bf, e_bi, e_bval}));
    chk({out_sum_we, out_sum} == {e_swe, e_sum}, {req, " R9 summary"},
        80'({out_sum_we, out_sum}), 80'({e_swe, e_sum}));
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1 R2";
      3'd1: return "R1 R3";
      3'd2: return "R4 R6";
      3'd3: return "R5 R6";
      3'd4: return "R1 R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10 op7";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_op = 0; in_mask = 0; in_mode = 0; in_merge = 0;
    in_record = 0; in_src_fld = 0; in_dst_old = 0; in_int = 0; in_int_is_r0 = 0; in_bit_tgt = 0;
    repeat (3) @(negedge clk);
    chk({out_valid, out_int_we, out_fld_we, out_bit_we, out_sum_we} == 5'b0, "R10 reset state",
        80'({out_valid, out_int_we, out_fld_we, out_bit_we, out_sum_we}), 80'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed: reduction corners (R2, R8)
    apply(3'd0, 4'hf, 4'ha, 1'b0, 1'b1, 4'ha, 4'h0, 64'd0, 1'b0, 5'd0, "R2 AND all-hit");
    apply(3'd0, 4'hf, 4'ha, 1'b0, 1'b1, 4'hb, 4'h0, 64'd0, 1'b0, 5'd0, "R2 AND one-miss");
    apply(3'd0, 4'h1, 4'h0, 1'b1, 1'b1, 4'he, 4'h0, 64'd0, 1'b0, 5'd0, "R2 OR single");
    apply(3'd1, 4'h0, 4'h0, 1'b0, 1'b1, 4'hf, 4'h0, 64'd0, 1'b0, 5'd0, "R3 R9 zero result");
    apply(3'd6, 4'hf, 4'h5, 1'b1, 1'b0, 4'h0, 4'h0, 64'd0, 1'b0, 5'b11110, "R8 target 7/2");
    // Directed: register-zero and immediates (R5, R11)
    apply(3'd3, 4'hf, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0, 64'hffff, 1'b1, 5'd0, "R5 r0 gives zero");
    apply(3'd3, 4'hf, ~4'h9, 1'b0, 1'b0, 4'h0, 4'h6, 64'h1, 1'b1, 5'd0, "R11 immediate load");
    apply(3'd3, 4'h5, 4'h0, 1'b1, 1'b0, 4'h0, 4'h8, 64'h1, 1'b1, 5'd0, "R11 set masked");
    apply(3'd3, 4'h5, 4'hf, 1'b1, 1'b0, 4'h0, 4'hf, 64'h1, 1'b1, 5'd0, "R11 clear masked");
    // Directed: move with merge and invert (R7), nibble probe (R4), idle op (R10)
    apply(3'd5, 4'h3, 4'h3, 1'b1, 1'b0, 4'h1, 4'hc, 64'd0, 1'b0, 5'd0, "R7 merge+invert");
    apply(3'd5, 4'h0, 4'h8, 1'b0, 1'b0, 4'hf, 4'hf, 64'd0, 1'b0, 5'd0, "R7 set via mode");
    apply(3'd2, 4'hf, 4'h6, 1'b0, 1'b0, 4'h0, 4'h0, 64'hfff6, 1'b0, 5'd0, "R4 nibble");
    apply(3'd7, 4'hf, 4'hf, 1'b1, 1'b1, 4'hf, 4'hf, 64'hf, 1'b0, 5'd31, "R10 op7 no write");

    // Idle cycle: no valid, no write (R10)
    @(negedge clk);
    chk({out_valid, out_int_we, out_fld_we, out_bit_we} == 4'b0, "R10 idle",
        80'({out_valid, out_int_we, out_fld_we, out_bit_we}), 80'(0));

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      apply(op, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
            4'($urandom), {$urandom, $urandom}, ($urandom_range(0, 3) == 0),
            5'($urandom), tag_of(op));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule